// File: doc/BRIEF.md
# Key Matrix Scanner and Code Generator

This block reads a keypad in which each key is a single switch that joins a sense line to a scan line. There are eight command sense lines, four system sense lines and eight scan lines. While the block is idle it pulls every scan line low, so any key pulls its sense line low. That wakes the block. It then waits through a debounce window and walks a single low scan line across all eight positions, one position per bit-time tick. At the end of the walk it reports the key as a numeric code.

A command key gives a 6-bit command code, and a system key gives a 5-bit system code. A mode input picks where the system number comes from. When the mode is low, system keys are ordinary keys. When the mode is high, the system lines are not keys at all. In that mode a permanent wire between one system line and one scan line supplies the system number for every command key. A frame transmitter downstream uses the reported codes. It keeps the result for as long as the key stays down, which it can see on a held flag.

Top module: `keypad_scan_encoder`

## Requirements
- R1: After reset, and whenever idle, every scan line is driven low (`drive_n` all 0), and `key_valid`, `key_held` and `illegal` are 0.
- R2: A single active sense line seen while idle starts a debounce of 10 ticks, followed by a scan of 8 ticks. If the key is applied in the cycle after a tick, `key_valid` is asserted in the cycle after the 18th tick. Ticks must be at least 3 clock cycles apart.
- R3: During the scan exactly one scan line is low, stepping from line 0 to line 7, one step per tick. Scan lines change only in the cycle after a tick.
- R4: A command key on sense line x and scan line d reports `key_is_sys`=0 and `cmd_code` = 8*x + d (x in bits 5:3, d in bits 2:0).
- R5: With `sys_mode`=0, a system key on system line z and scan line d reports `key_is_sys`=1, `sys_valid`=1 and `sys_code` = 8*z + d (z in bits 4:3).
- R6: Two or more active sense lines while idle raise `illegal`. No scan starts and no code is reported, and the scan lines stay low.
- R7: If a pressed sense line touches several scan lines, the highest-numbered one (the last one scanned) gives the code. The same rule applies to a wired system link.
- R8: With `sys_mode`=1, system lines neither wake the block nor count as illegal. A command key then reports `sys_valid`=1 with `sys_code` = 8*z + d taken from the wired link. If no link is present it reports `sys_valid`=0. With `sys_mode`=0, a command key reports `sys_valid`=0.
- R9: `key_valid` is a one-cycle pulse, and `key_held` rises with it. While the key stays down, `key_held` stays 1, only the matched scan line is low, and the codes stay stable. After release, `key_held` falls at a tick.
- R10: A key released before the debounce window ends produces no report, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle bit-time enable |
| sys_mode | input | 1 | 0: system keys, 1: wired system link |
| sense_cmd_n | input | 8 | Command sense lines, low = connected |
| sense_sys_n | input | 4 | System sense lines, low = connected |
| drive_n | output | 8 | Scan lines, low = active |
| key_valid | output | 1 | One-cycle report pulse |
| key_held | output | 1 | Reported key still pressed |
| key_is_sys | output | 1 | Report came from a system key |
| cmd_code | output | 6 | Command code |
| sys_code | output | 5 | System code |
| sys_valid | output | 1 | `sys_code` carries a system number |
| illegal | output | 1 | Multiple sense lines active while idle |

## Verification
The assertions check the following on every cycle:
- the scan lines are either all low or exactly one low;
- scan lines move only in the cycle after a tick;
- the report pulse lasts one cycle and coincides with the held flag;
- the codes stay stable while the flag is high;
- an illegal press keeps the block idle.

Code values, the last-line-wins rule, the 18-tick latency, bounce rejection, and the two system-number sources depend on which keys and wires are present. Only the scoreboard scenarios, which compare each report against values computed from the key positions, can show those.

// File: rtl/keypad_scan_encoder.sv
module keypad_scan_encoder #(
  parameter int N_CMD = 8,
  parameter int N_SYS = 4,
  parameter int N_DRV = 8,
  parameter int FRAME_TICKS = 18
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   bit_tick,
  input  logic                                   sys_mode,
  input  logic [N_CMD-1:0]                       sense_cmd_n,
  input  logic [N_SYS-1:0]                       sense_sys_n,
  output logic [N_DRV-1:0]                       drive_n,
  output logic                                   key_valid,
  output logic                                   key_held,
  output logic                                   key_is_sys,
  output logic [$clog2(N_CMD)+$clog2(N_DRV)-1:0] cmd_code,
  output logic [$clog2(N_SYS)+$clog2(N_DRV)-1:0] sys_code,
  output logic                                   sys_valid,
  output logic                                   illegal
);
  localparam int DW = $clog2(N_DRV);
  localparam int CW = $clog2(N_CMD);
  localparam int SW = $clog2(N_SYS);
  localparam int NL = N_CMD + N_SYS;
  localparam int DEB_TICKS = FRAME_TICKS - N_DRV;
  localparam int TW = $clog2(DEB_TICKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DEB, ST_SCAN, ST_HOLD} st_e;
  st_e state;

  logic [NL-1:0] sync1, sync2, key_mask;
  logic [TW-1:0] deb_cnt;
  logic [DW-1:0] idx, hit_dr;
  logic          hit_found, wsys_found;
  logic [SW+DW-1:0] wsys_code;

  wire [N_CMD-1:0] x_lo = ~sync2[N_CMD-1:0];
  wire [N_SYS-1:0] z_lo = ~sync2[NL-1:N_CMD];
  wire [NL-1:0]    act  = {sys_mode ? {N_SYS{1'b0}} : z_lo, x_lo};
  wire             hit  = |(~sync2 & key_mask);
  wire             wz   = sys_mode && |z_lo;
  wire             last = (idx == DW'(N_DRV - 1));
  wire             tick_scan = (state == ST_SCAN) && bit_tick;

  int n_act, kfirst, kline, zfirst;
  logic kis_sys;
  always_comb begin
    n_act = $countones(act);
    kfirst = 0;
    for (int i = NL - 1; i >= 0; i--) if (key_mask[i]) kfirst = i;
    kis_sys = |key_mask[NL-1:N_CMD];
    kline = kis_sys ? kfirst - N_CMD : kfirst;
    zfirst = 0;
    for (int i = N_SYS - 1; i >= 0; i--) if (z_lo[i]) zfirst = i;
  end

  wire [DW-1:0]    fin_dr = hit ? idx : hit_dr;
  wire             fin_ok = hit || hit_found;
  wire [SW+DW-1:0] fin_w  = wz ? {SW'(zfirst), idx} : wsys_code;
  wire             fin_wf = wz || wsys_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
    end else begin
      sync1 <= {sense_sys_n, sense_cmd_n};
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      key_mask   <= '0;
      deb_cnt    <= '0;
      idx        <= '0;
      hit_dr     <= '0;
      hit_found  <= 1'b0;
      wsys_found <= 1'b0;
      wsys_code  <= '0;
    end else begin
      case (state)
        ST_IDLE:
          if (n_act == 1) begin
            state      <= ST_DEB;
            key_mask   <= act;
            deb_cnt    <= '0;
            hit_found  <= 1'b0;
            wsys_found <= 1'b0;
          end
        ST_DEB:
          if (bit_tick) begin
            if (deb_cnt == TW'(DEB_TICKS - 1)) begin
              state <= (act == key_mask) ? ST_SCAN : ST_IDLE;
              idx   <= '0;
            end else begin
              deb_cnt <= deb_cnt + 1'b1;
            end
          end
        ST_SCAN:
          if (bit_tick) begin
            hit_dr     <= fin_dr;
            hit_found  <= fin_ok;
            wsys_code  <= fin_w;
            wsys_found <= fin_wf;
            if (last) state <= fin_ok ? ST_HOLD : ST_IDLE;
            else idx <= idx + 1'b1;
          end
        ST_HOLD:
          if (bit_tick && !hit) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_valid  <= 1'b0;
      key_is_sys <= 1'b0;
      cmd_code   <= '0;
      sys_code   <= '0;
      sys_valid  <= 1'b0;
    end else begin
      key_valid <= tick_scan && last && fin_ok;
      if (tick_scan && last && fin_ok) begin
        key_is_sys <= kis_sys;
        if (kis_sys) begin
          sys_code  <= {SW'(kline), fin_dr};
          sys_valid <= 1'b1;
        end else begin
          cmd_code  <= {CW'(kline), fin_dr};
          sys_valid <= sys_mode && fin_wf;
          if (sys_mode && fin_wf) sys_code <= fin_w;
        end
      end
    end
  end

  always_comb begin
    case (state)
      ST_SCAN: drive_n = ~(N_DRV'(1) << idx);
      ST_HOLD: drive_n = ~(N_DRV'(1) << hit_dr);
      default: drive_n = '0;
    endcase
  end

  assign key_held = (state == ST_HOLD);
  assign illegal  = (state == ST_IDLE) && (n_act > 1);
endmodule

// File: rtl/keypad_scan_encoder_chk.sv
module keypad_scan_encoder_chk #(
  parameter int N_CMD = 8,
  parameter int N_SYS = 4,
  parameter int N_DRV = 8
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   bit_tick,
  input logic [N_DRV-1:0]                       drive_n,
  input logic                                   key_valid,
  input logic                                   key_held,
  input logic                                   illegal,
  input logic [$clog2(N_CMD)+$clog2(N_DRV)-1:0] cmd_code,
  input logic [$clog2(N_SYS)+$clog2(N_DRV)-1:0] sys_code
);
  // R3
  drive_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~drive_n) == 1) || (drive_n == '0));
  // R3
  drive_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drive_n) |-> $past(bit_tick));
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);
  // R9
  valid_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> key_held);
  // R9
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_held && $past(key_held)) |-> ($stable(cmd_code) && $stable(sys_code)));
  // R6
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (drive_n == '0 && !key_held && !key_valid));
endmodule

bind keypad_scan_encoder keypad_scan_encoder_chk #(
  .N_CMD(N_CMD), .N_SYS(N_SYS), .N_DRV(N_DRV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .drive_n(drive_n),
  .key_valid(key_valid), .key_held(key_held), .illegal(illegal),
  .cmd_code(cmd_code), .sys_code(sys_code)
);

// File: tb/keypad_scan_encoder_tb.sv
module keypad_scan_encoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, sys_mode = 1'b0;
  logic [1:0] div = '0;
  logic bit_tick;
  logic [7:0] sense_cmd_n, drive_n;
  logic [3:0] sense_sys_n;
  logic key_valid, key_held, key_is_sys, sys_valid, illegal;
  logic [5:0] cmd_code;
  logic [4:0] sys_code;

  logic [7:0] xc [8];
  logic [7:0] zc [4];
  logic [7:0] wc [4];

  int errors = 0, checks = 0, ticks = 0, press_ticks = 0, cyc = 0;
  bit done = 0;

  typedef struct packed { logic is_sys; logic [5:0] cmd; logic [4:0] sys; logic sv; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bit_tick = (div == 2'd3);
  always @(posedge clk) begin
    div <= div + 2'd1;
    if (bit_tick) ticks <= ticks + 1;
  end

  always_comb begin
    for (int i = 0; i < 8; i++) sense_cmd_n[i] = ~|(xc[i] & ~drive_n);
    for (int i = 0; i < 4; i++) sense_sys_n[i] = ~|((zc[i] | wc[i]) & ~drive_n);
  end

  keypad_scan_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sys_mode(sys_mode),
    .sense_cmd_n(sense_cmd_n), .sense_sys_n(sense_sys_n), .drive_n(drive_n),
    .key_valid(key_valid), .key_held(key_held), .key_is_sys(key_is_sys),
    .cmd_code(cmd_code), .sys_code(sys_code), .sys_valid(sys_valid), .illegal(illegal)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected reports
  always @(negedge clk) begin
    if (rst_n && key_valid) begin
      if (q.size() == 0) check(0, "R6/R8/R10 unexpected report", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(ticks - press_ticks == 18, "R2 latency ticks", ticks - press_ticks, 18);
        check(key_is_sys == e.is_sys, "R4/R5 key_is_sys", key_is_sys, e.is_sys);
        if (!e.is_sys) check(cmd_code == e.cmd, "R4/R7 cmd_code", cmd_code, e.cmd);
        check(sys_valid == e.sv, "R5/R8 sys_valid", sys_valid, e.sv);
        if (e.sv) check(sys_code == e.sys, "R5/R8 sys_code", sys_code, e.sys);
        check(key_held == 1'b1, "R9 held with valid", key_held, 1);
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic align();
    int t0 = ticks;
    do @(negedge clk); while (ticks == t0);
  endtask

  task automatic clear_keys();
    for (int i = 0; i < 8; i++) xc[i] = '0;
    for (int i = 0; i < 4; i++) zc[i] = '0;
  endtask

  function automatic int top_bit(input logic [7:0] m);
    int r = 0;
    for (int i = 0; i < 8; i++) if (m[i]) r = i;
    return r;
  endfunction

  task automatic run_key(input bit is_z, input int line, input logic [7:0] mask,
                         input bit wired, input int wl, input logic [7:0] wmask);
    exp_t e;
    int d = top_bit(mask);
    e.is_sys = is_z;
    e.cmd = 6'(line * 8 + d);
    if (is_z) begin e.sys = 5'(line * 8 + d); e.sv = 1'b1; end
    else if (sys_mode && wired) begin e.sys = 5'(wl * 8 + top_bit(wmask)); e.sv = 1'b1; end
    else begin e.sys = '0; e.sv = 1'b0; end
    q.push_back(e);
    align();
    if (is_z) zc[line] = mask; else xc[line] = mask;
    press_ticks = ticks;
    for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
    check(q.size() == 0, "R2 report arrived", q.size(), 0);
    repeat (20) @(negedge clk);
    check(key_held == 1'b1, "R9 held while pressed", key_held, 1);
    check(drive_n == ~(8'd1 << d), "R9 hold drive", drive_n, ~(8'd1 << d) & 8'hff);
    clear_keys();
    repeat (12) @(negedge clk);
    check(key_held == 1'b0, "R9 held falls", key_held, 0);
    check(drive_n == 8'h00, "R1 idle drive", drive_n, 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    clear_keys();
    for (int i = 0; i < 4; i++) wc[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(drive_n == 8'h00, "R1 reset drive", drive_n, 0);
    check(!key_valid && !key_held && !illegal, "R1 reset flags",
          {key_valid, key_held, illegal}, 0);

    run_key(0, 3, 8'b0010_0000, 0, 0, 0);     // R4 code 29
    run_key(0, 7, 8'b1000_0000, 0, 0, 0);     // R4 code 63
    run_key(0, 0, 8'b0000_0001, 0, 0, 0);     // R4 code 0
    run_key(1, 2, 8'b0100_0000, 0, 0, 0);     // R5 code 22
    run_key(0, 2, 8'b0100_0010, 0, 0, 0);     // R7 last line 6 wins -> 22
    run_key(1, 1, 8'b0000_1001, 0, 0, 0);     // R7 system -> 11

    // R6 two command lines
    align();
    xc[1] = 8'b0000_0100; xc[4] = 8'b0000_0100;
    repeat (10) @(negedge clk);
    check(illegal == 1'b1, "R6 illegal X+X", illegal, 1);
    repeat (100) @(negedge clk);
    check(drive_n == 8'h00 && !key_held, "R6 no scan", drive_n, 0);
    clear_keys();
    repeat (10) @(negedge clk);
    check(illegal == 1'b0, "R6 illegal clears", illegal, 0);
    // R6 command plus system line
    xc[1] = 8'b0000_0001; zc[0] = 8'b0000_1000;
    repeat (10) @(negedge clk);
    check(illegal == 1'b1, "R6 illegal X+Z", illegal, 1);
    clear_keys();
    repeat (20) @(negedge clk);

    // R10 bounce shorter than debounce
    align();
    xc[6] = 8'b0000_1000;
    repeat (20) @(negedge clk);
    clear_keys();
    repeat (150) @(negedge clk);
    check(!key_held && drive_n == 8'h00, "R10 bounce ignored", key_held, 0);

    // R8 wired link mode
    sys_mode = 1'b1;
    wc[3] = 8'b0001_0000;
    repeat (150) @(negedge clk);
    check(!key_held && !illegal, "R8 wire does not wake", {key_held, illegal}, 0);
    run_key(0, 5, 8'b0000_0010, 1, 3, 8'b0001_0000);   // R8 cmd 41 sys 28
    wc[3] = 8'b0001_0001;
    run_key(0, 4, 8'b0000_0100, 1, 3, 8'b0001_0001);   // R7/R8 sys 28
    wc[3] = '0;
    run_key(0, 5, 8'b0000_0010, 0, 0, 0);              // R8 no link
    sys_mode = 1'b0;
    run_key(0, 6, 8'b0000_1000, 0, 0, 0);              // R8 mode low -> sys_valid 0

    check(q.size() == 0, "R2 queue drained", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule